// File: doc/BRIEF.md
# Big-endian load/store byte lane unit

This block connects a 32-bit processor datapath to a data memory that is one word wide. Each request carries a base register value, a signed 16-bit displacement, an access width (byte, half-word or word), a direction and, for loads, a flag that selects signed or unsigned extension. The block forms the effective address and sends the memory a word-aligned address. For stores it also produces per-lane write strobes and write data placed on the correct lanes. For loads it raises a read strobe and, one cycle later, returns the addressed field taken from the memory word and widened to 32 bits.

Lanes follow big-endian order. Byte offset 0 inside a word is the most significant lane (bits 31:24), and byte offset 3 is the least significant lane (bits 7:0). The block checks alignment against the access width. A request that breaks the rule raises a fault strobe in the same cycle. That request writes nothing, reads nothing and gets no response.

Top module: `be_lane_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` is that address with its two low bits forced to zero.
- R2: `req_size` is encoded as 2'b00 byte, 2'b01 half-word, 2'b10 word. A word access needs effective-address bits [1:0] equal to 0. A half-word access needs bit 0 equal to 0. A byte access is never misaligned. Code 2'b11 always counts as a fault.
- R3: `align_fault` is high in exactly the cycles where `req_valid` is high and the request breaks R2, and low in all other cycles.
- R4: While `align_fault` is high, `mem_wen` is 4'b0000 and `mem_ren` is low. Memory contents stay unchanged and no response follows.
- R5: A valid byte store sets exactly one strobe, `mem_wen[3 - ea[1:0]]`, where `mem_wen[i]` guards bits 8i+7:8i. The store byte `req_wdata[7:0]` is copied to all four lanes of `mem_wdata`.
- R6: A valid half-word store sets `mem_wen` to 4'b1100 when ea[1] is 0 and to 4'b0011 when ea[1] is 1. `req_wdata[15:0]` is copied into both halves of `mem_wdata`.
- R7: A valid word store sets `mem_wen` to 4'b1111 and passes `req_wdata` through unchanged.
- R8: A valid, aligned load raises `mem_ren` in the request cycle. `rsp_valid` is high in the following cycle, and `rsp_data` is formed from `mem_rdata` as presented in that cycle. Loads may be issued in back-to-back cycles.
- R9: Load fields are taken in big-endian order. A byte at offset k comes from `mem_rdata[31-8k -: 8]`. A half-word at offset 0 comes from bits 31:16, and one at offset 2 comes from bits 15:0. A word is the whole of `mem_rdata`.
- R10: When `req_signed` is 0, a byte or half-word load fills the upper result bits with zeros.
- R11: When `req_signed` is 1, a byte or half-word load copies the field's top bit into the upper result bits. On word loads the flag has no effect.
- R12: During and after a synchronous active-low reset, `rsp_valid` is 0. A load issued in a reset cycle gets no response. Whenever `rsp_valid` is 0, `rsp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (see R2) |
| req_signed | input | 1 | Load extension: 1 signed, 0 unsigned |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-justified |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wen | output | 4 | Per-lane write strobes, bit i guards bits 8i+7:8i |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_ren | output | 1 | Read strobe for an aligned load |
| mem_rdata | input | 32 | Memory word, returned one cycle after `mem_ren` |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Extended load result |
| align_fault | output | 1 | Misaligned or illegal-size request in this cycle |

## Verification
The embedded properties assume that memory returns the word for a read strobe on the next cycle, and that `req_size`, `req_write` and `req_signed` are settled whenever `req_valid` is high. The bench's memory model gives a registered read with one cycle of latency. All requests are driven on the falling edge, and each request stays in place for one full cycle. Every address the stimulus forms falls inside the model's sixteen-word window, so each response can be predicted from the prior stores alone. Illegal size codes and misaligned addresses are sent on purpose, because the fault path is itself under test.

// File: rtl/be_lsu_pkg.sv
// Package: shared types for the big-endian lane unit.
// Assumes 8-bit lanes; the access width code is fixed by R2.
package be_lsu_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

endpackage

// File: rtl/lsu_addr_gen.sv
// Effective-address generator and alignment checker.
// Adds a sign-extended displacement to the base, splits the sum into a
// word-aligned address and a lane offset, and flags accesses whose offset
// does not suit the access width. Assumes ADDR_W > OFFS_W.
module lsu_addr_gen
    import be_lsu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int OFFS_W   = 16,
    parameter int OFS_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  acc_size_e           size,
    input  logic [ADDR_W-1:0]   base,
    input  logic [OFFS_W-1:0]   offset,
    output logic [ADDR_W-1:0]   word_addr,
    output logic [OFS_BITS-1:0] lane_ofs,
    output logic                misalign,
    output logic                fault
);

    localparam int EXT_W = ADDR_W - OFFS_W;

    logic [ADDR_W-1:0] eff_addr;

    // Sum base and sign-extended displacement.
    always_comb begin
        eff_addr  = base + {{EXT_W{offset[OFFS_W-1]}}, offset};
        lane_ofs  = eff_addr[OFS_BITS-1:0];
        word_addr = {eff_addr[ADDR_W-1:OFS_BITS], {OFS_BITS{1'b0}}};
    end

    // Apply the width-dependent alignment rule.
    always_comb begin
        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = lane_ofs[0];
            SZ_WORD: misalign = |lane_ofs;
            default: misalign = 1'b1;
        endcase
        fault = req_valid & misalign;
    end

    // R2
    byte_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && size == SZ_BYTE) |-> !fault);

    // R3
    fault_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> req_valid);

endmodule

// File: rtl/lsu_store_lane.sv
// Store lane placer: builds per-lane write strobes and copies the
// right-justified store data onto every lane that the width could touch.
// Lane i covers bits 8i+7:8i and holds big-endian byte offset LANES-1-i.
// Assumes wr_en is already gated by the alignment check.
module lsu_store_lane
    import be_lsu_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int OFS_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  acc_size_e           size,
    input  logic [OFS_BITS-1:0] lane_ofs,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/LANE_W-1:0] be,
    output logic [DATA_W-1:0]   lane_data
);

    localparam int LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFS_BITS-1:0] BOFF = OFS_BITS'(LANES - 1 - i);

        // Strobe for this lane from width and offset.
        always_comb begin
            unique case (size)
                SZ_BYTE: be[i] = wr_en & (lane_ofs == BOFF);
                SZ_HALF: be[i] = wr_en & (lane_ofs[OFS_BITS-1:1] == BOFF[OFS_BITS-1:1]);
                SZ_WORD: be[i] = wr_en;
                default: be[i] = 1'b0;
            endcase
        end

        // Data for this lane from the replicated store unit.
        always_comb begin
            unique case (size)
                SZ_BYTE: lane_data[i*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
                SZ_HALF: lane_data[i*LANE_W +: LANE_W] = BOFF[0] ? wdata[LANE_W-1:0]
                                                                 : wdata[2*LANE_W-1:LANE_W];
                default: lane_data[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
            endcase
        end
    end

    // R5
    byte_store_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && size == SZ_BYTE) |-> $countones(be) == 1);

    // R6
    half_store_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && size == SZ_HALF) |-> $countones(be) == 2);

    // R4
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> be == '0);

endmodule

// File: rtl/lsu_load_align.sv
// Load aligner: records the width, extension and lane offset of an issued
// read, then in the next cycle shifts the addressed big-endian field to the
// top of the returned word and widens it. Assumes memory presents the word
// one cycle after the read strobe.
module lsu_load_align
    import be_lsu_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int OFS_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_issue,
    input  acc_size_e           size,
    input  logic                sgn,
    input  logic [OFS_BITS-1:0] lane_ofs,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data
);

    localparam int HALF_W = 2 * LANE_W;
    localparam int SH_W   = OFS_BITS + 3;

    logic                vld_q;
    acc_size_e           size_q;
    logic                sgn_q;
    logic [OFS_BITS-1:0] ofs_q;
    logic [DATA_W-1:0]   shifted;
    logic [LANE_W-1:0]   byte_f;
    logic [HALF_W-1:0]   half_f;
    logic [DATA_W-1:0]   result;

    // Hold the context of the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            size_q <= SZ_WORD;
            sgn_q  <= 1'b0;
            ofs_q  <= '0;
        end else begin
            vld_q <= rd_issue;
            if (rd_issue) begin
                size_q <= size;
                sgn_q  <= sgn;
                ofs_q  <= lane_ofs;
            end
        end
    end

    // Move the addressed field to the top and extend it.
    always_comb begin
        shifted = mem_rdata << {ofs_q, 3'b000};
        byte_f  = shifted[DATA_W-1 -: LANE_W];
        half_f  = shifted[DATA_W-1 -: HALF_W];
        unique case (size_q)
            SZ_BYTE: result = {{(DATA_W-LANE_W){sgn_q & byte_f[LANE_W-1]}}, byte_f};
            SZ_HALF: result = {{(DATA_W-HALF_W){sgn_q & half_f[HALF_W-1]}}, half_f};
            default: result = mem_rdata;
        endcase
        rsp_valid = vld_q;
        rsp_data  = vld_q ? result : '0;
    end

    // R8
    rsp_follows_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_issue |=> rsp_valid);

    // R8
    no_rsp_without_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_issue |=> !rsp_valid);

    // R10
    zero_ext_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && size_q == SZ_BYTE && !sgn_q) |-> rsp_data[DATA_W-1:LANE_W] == '0);

    // R11
    sign_ext_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && size_q == SZ_HALF && sgn_q)
            |-> rsp_data[DATA_W-1:HALF_W] == {(DATA_W-HALF_W){rsp_data[HALF_W-1]}});

endmodule

// File: rtl/be_lane_unit.sv
// Top of the big-endian load/store lane unit. Joins the address generator,
// the store lane placer and the load aligner, and blocks all memory activity
// for a faulting request. Assumes one request per cycle and a data memory
// with one cycle of read latency.
module be_lane_unit
    import be_lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFFS_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [1:0]              req_size,
    input  logic                    req_signed,
    input  logic [ADDR_W-1:0]       req_base,
    input  logic [OFFS_W-1:0]       req_offset,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [DATA_W/8-1:0]     mem_wen,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    mem_ren,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data,
    output logic                    align_fault
);

    localparam int LANES    = DATA_W / LANE_W;
    localparam int OFS_BITS = $clog2(LANES);

    acc_size_e           size_e;
    logic [OFS_BITS-1:0] lane_ofs;
    logic                misalign;
    logic                wr_go;

    // Decode the width code and gate the memory strobes.
    always_comb begin
        size_e  = acc_size_e'(req_size);
        wr_go   = req_valid & req_write & ~misalign;
        mem_ren = req_valid & ~req_write & ~misalign;
    end

    lsu_addr_gen #(
        .ADDR_W  (ADDR_W),
        .OFFS_W  (OFFS_W),
        .OFS_BITS(OFS_BITS)
    ) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .size     (size_e),
        .base     (req_base),
        .offset   (req_offset),
        .word_addr(mem_addr),
        .lane_ofs (lane_ofs),
        .misalign (misalign),
        .fault    (align_fault)
    );

    lsu_store_lane #(
        .DATA_W  (DATA_W),
        .OFS_BITS(OFS_BITS)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_go),
        .size     (size_e),
        .lane_ofs (lane_ofs),
        .wdata    (req_wdata),
        .be       (mem_wen),
        .lane_data(mem_wdata)
    );

    lsu_load_align #(
        .DATA_W  (DATA_W),
        .OFS_BITS(OFS_BITS)
    ) load_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (mem_ren),
        .size     (size_e),
        .sgn      (req_signed),
        .lane_ofs (lane_ofs),
        .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data)
    );

    // R4
    fault_blocks_memory_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (mem_wen == '0 && !mem_ren));

    // R7
    word_store_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 2'b10 && !align_fault)
            |-> (mem_wen == '1 && mem_wdata == req_wdata));

endmodule

// File: tb/be_lane_unit_tb_top.sv
`timescale 1ns/1ps
module be_lane_unit_tb_top;

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic        sg;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] wd;
        logic        flt;
        logic [3:0]  wen;
        logic [31:0] wdx;
        logic [31:0] adr;
        logic [31:0] rsp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 28;
    // Memory preset: 0x100 = 01234567, 0x104 = 89ABCDEF, others zero.
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 1'b0, 32'h100, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h100, 32'h00000001, 4'd9},  // R9
        '{1'b0, 2'b00, 1'b0, 32'h100, 16'h0003, 32'h0, 1'b0, 4'h0, 32'h0, 32'h100, 32'h00000067, 4'd9},  // R9
        '{1'b0, 2'b00, 1'b1, 32'h108, 16'hFFFC, 32'h0, 1'b0, 4'h0, 32'h0, 32'h104, 32'hFFFFFF89, 4'd11}, // R11
        '{1'b0, 2'b00, 1'b0, 32'h100, 16'h0005, 32'h0, 1'b0, 4'h0, 32'h0, 32'h104, 32'h000000AB, 4'd10}, // R10
        '{1'b0, 2'b01, 1'b0, 32'h104, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h104, 32'h000089AB, 4'd10}, // R10
        '{1'b0, 2'b01, 1'b1, 32'h106, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h104, 32'hFFFFCDEF, 4'd11}, // R11
        '{1'b0, 2'b01, 1'b1, 32'h100, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h100, 32'h00000123, 4'd11}, // R11
        '{1'b0, 2'b10, 1'b1, 32'h104, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h104, 32'h89ABCDEF, 4'd11}, // R11
        '{1'b0, 2'b10, 1'b0, 32'h101, 16'h0003, 32'h0, 1'b0, 4'h0, 32'h0, 32'h104, 32'h89ABCDEF, 4'd1},  // R1
        '{1'b0, 2'b10, 1'b0, 32'h102, 16'h0000, 32'h0, 1'b1, 4'h0, 32'h0, 32'h100, 32'h0, 4'd2},         // R2
        '{1'b0, 2'b01, 1'b0, 32'h103, 16'h0000, 32'h0, 1'b1, 4'h0, 32'h0, 32'h100, 32'h0, 4'd2},         // R2
        '{1'b1, 2'b00, 1'b0, 32'h109, 16'h0000, 32'h000000A5, 1'b0, 4'b0100, 32'hA5A5A5A5, 32'h108, 32'h0, 4'd5}, // R5
        '{1'b0, 2'b10, 1'b0, 32'h108, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h108, 32'h00A50000, 4'd5},  // R5
        '{1'b1, 2'b01, 1'b0, 32'h10A, 16'h0000, 32'h1234BEEF, 1'b0, 4'b0011, 32'hBEEFBEEF, 32'h108, 32'h0, 4'd6}, // R6
        '{1'b0, 2'b10, 1'b0, 32'h108, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h108, 32'h00A5BEEF, 4'd6},  // R6
        '{1'b1, 2'b01, 1'b0, 32'h10C, 16'h0000, 32'h0000CAFE, 1'b0, 4'b1100, 32'hCAFECAFE, 32'h10C, 32'h0, 4'd6}, // R6
        '{1'b1, 2'b10, 1'b0, 32'h110, 16'h0000, 32'hDEADBEEF, 1'b0, 4'b1111, 32'hDEADBEEF, 32'h110, 32'h0, 4'd7}, // R7
        '{1'b1, 2'b10, 1'b0, 32'h10E, 16'h0000, 32'h55555555, 1'b1, 4'h0, 32'h0, 32'h10C, 32'h0, 4'd4},  // R4
        '{1'b1, 2'b01, 1'b0, 32'h10D, 16'h0000, 32'h66666666, 1'b1, 4'h0, 32'h0, 32'h10C, 32'h0, 4'd4},  // R4
        '{1'b0, 2'b10, 1'b0, 32'h10C, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h10C, 32'hCAFE0000, 4'd4},  // R4
        '{1'b0, 2'b10, 1'b0, 32'h110, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h110, 32'hDEADBEEF, 4'd7},  // R7
        '{1'b1, 2'b11, 1'b0, 32'h114, 16'h0000, 32'h11111111, 1'b1, 4'h0, 32'h0, 32'h114, 32'h0, 4'd2},  // R2
        '{1'b0, 2'b10, 1'b0, 32'h114, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h114, 32'h00000000, 4'd4},  // R4
        '{1'b1, 2'b00, 1'b0, 32'h117, 16'h0000, 32'h0000007F, 1'b0, 4'b0001, 32'h7F7F7F7F, 32'h114, 32'h0, 4'd5}, // R5
        '{1'b0, 2'b00, 1'b1, 32'h117, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h114, 32'h0000007F, 4'd11}, // R11
        '{1'b0, 2'b00, 1'b1, 32'h114, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h114, 32'h00000000, 4'd9},  // R9
        '{1'b1, 2'b00, 1'b0, 32'h200, 16'hFF10, 32'h000000C3, 1'b0, 4'b1000, 32'hC3C3C3C3, 32'h110, 32'h0, 4'd1}, // R1
        '{1'b0, 2'b10, 1'b0, 32'h110, 16'h0000, 32'h0, 1'b0, 4'h0, 32'h0, 32'h110, 32'hC3ADBEEF, 4'd1}   // R1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic        req_signed = 1'b0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_wen;
    logic [31:0] mem_wdata;
    logic        mem_ren;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        align_fault;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    logic [31:0] mem [16];

    always #2 clk = ~clk;

    be_lane_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_signed (req_signed),
        .req_base   (req_base),
        .req_offset (req_offset),
        .req_wdata  (req_wdata),
        .mem_addr   (mem_addr),
        .mem_wen    (mem_wen),
        .mem_wdata  (mem_wdata),
        .mem_ren    (mem_ren),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .align_fault(align_fault)
    );

    // Behavioural word memory: lane writes, registered read.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'h0;
            mem[0]    <= 32'h01234567;
            mem[1]    <= 32'h89ABCDEF;
            mem_rdata <= 32'h0;
        end else begin
            for (int l = 0; l < 4; l++)
                if (mem_wen[l]) mem[mem_addr[5:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
            if (mem_ren) mem_rdata <= mem[mem_addr[5:2]];
        end
    end

    task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [1:0] sz, input logic sg,
                         input logic [31:0] b, input logic [15:0] o, input logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sg;
        req_base = b; req_offset = o; req_wdata = wd;
    endtask

    task automatic idle();
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state (R12, R3)
        repeat (3) @(negedge clk);
        #0.5;
        check(12, "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        check(12, "rsp_data in reset", rsp_data, 32'h0);
        check(3, "align_fault idle", {31'b0, align_fault}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            drive(VECS[v].wr, VECS[v].sz, VECS[v].sg, VECS[v].base, VECS[v].off, VECS[v].wd);
            #0.5;
            check(int'(VECS[v].rq), "align_fault", {31'b0, align_fault}, {31'b0, VECS[v].flt});
            check(1, "mem_addr", mem_addr, VECS[v].adr);
            if (VECS[v].wr) begin
                check(int'(VECS[v].rq), "mem_wen", {28'b0, mem_wen}, {28'b0, VECS[v].wen});
                if (!VECS[v].flt) check(int'(VECS[v].rq), "mem_wdata", mem_wdata, VECS[v].wdx);
            end else begin
                check(int'(VECS[v].rq), "mem_ren", {31'b0, mem_ren}, {31'b0, !VECS[v].flt});
            end
            @(negedge clk);
            idle();
            #0.5;
            // R3: fault lasts only for the request cycle
            check(3, "align_fault after req", {31'b0, align_fault}, 32'h0);
            if (!VECS[v].wr) begin
                check(8, "rsp_valid", {31'b0, rsp_valid}, {31'b0, !VECS[v].flt});
                if (!VECS[v].flt) check(int'(VECS[v].rq), "rsp_data", rsp_data, VECS[v].rsp);
            end
        end

        // R8: back-to-back loads
        @(negedge clk);
        drive(1'b0, 2'b00, 1'b0, 32'h104, 16'h0001, 32'h0);
        @(negedge clk);
        drive(1'b0, 2'b01, 1'b0, 32'h104, 16'h0002, 32'h0);
        #0.5;
        check(8, "b2b second mem_ren", {31'b0, mem_ren}, 32'h1);
        check(8, "b2b first rsp", rsp_data, 32'h000000AB);
        @(negedge clk);
        idle();
        #0.5;
        check(8, "b2b second rsp_valid", {31'b0, rsp_valid}, 32'h1);
        check(9, "b2b second rsp", rsp_data, 32'h0000CDEF);
        @(negedge clk);
        #0.5;
        // R12: idle output is zero
        check(12, "idle rsp_valid", {31'b0, rsp_valid}, 32'h0);
        check(12, "idle rsp_data", rsp_data, 32'h0);

        // R12: load issued during reset gets no response
        @(negedge clk);
        drive(1'b0, 2'b10, 1'b0, 32'h100, 16'h0000, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        idle();
        rst_n = 1'b1;
        #0.5;
        check(12, "rsp after reset cycle", {31'b0, rsp_valid}, 32'h0);
        check(12, "rsp_data after reset cycle", rsp_data, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule